// File: doc/BRIEF.md
# Alternating-Channel ADC Read Sequencer

This controller runs a delta-sigma converter that has a serial port (a serial clock, a command input, a data output and an active-low data-ready line). It makes the converter's input multiplexer alternate between two channels, one conversion on each channel in turn. When data-ready falls, the controller clocks out the pending 32-bit conversion result. It then writes the multiplexer register with the code of the other channel. Last, it sends the read-data command, so the next result can be shifted out as soon as data-ready falls again, with no command first.

Each frame has 64 serial clocks and always runs in the same order: readback, multiplexer write, read-data command. This order matters because any register write restarts the converter's filter and throws away the result that has not been read. The serial clock stays idle for the whole wait between frames, because stray clock edges could be decoded as a command.

Every delivered word carries a tag naming the channel that was selected while that conversion ran. If data-ready falls while a frame is still being shifted, a sticky error flag is set.

Top module: `adc_alt_seq`

## Requirements
- R1: While reset is high and after it, `sclk` is low, and `res_valid` and `overrun` are 0. The first transfer after reset selects channel 1. It is 32 serial clocks carrying the bytes `MUX_WR_OP`, `MUX_CNT`, `CODE_ONE`, `RDATA_OP`, in that order, each byte MSB first.
- R2: Between the end of a configuration transfer and the next falling edge of `drdy_n`, `sclk` has no edges.
- R3: A falling edge of `drdy_n` starts a readback of exactly 32 `sclk` pulses. `dout` is sampled on each falling `sclk` edge, MSB first. The word is then presented on `res_data` with a `res_valid` pulse one clock long.
- R4: Each readback finishes and its result is delivered before the first `sclk` pulse of the following multiplexer write.
- R5: After every readback, the multiplexer write carries the code of the channel not used by the conversion just read. The channels alternate 1, 2, 1, 2 …
- R6: `res_chan` gives the channel selected during the conversion being delivered (0 = channel 1, 1 = channel 2). The first result is tagged 0.
- R7: The read-data command is the last byte of every configuration transfer. The result is then clocked out with no command before it.
- R8: The `sclk` period is `2*SCLK_HALF` clock cycles. `din` changes only together with a rising `sclk` edge.
- R9: A falling edge of `drdy_n` that is detected while a transfer is in progress sets `overrun`, which stays set until reset. That edge does not start an extra frame, and the frame in progress completes unchanged.
- R10: `din` is held low during every readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| dout | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock to the converter |
| din | output | 1 | Serial command/data to the converter |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | 32 | Conversion result |
| res_chan | output | 1 | Channel tag of the result |
| overrun | output | 1 | Sticky data-ready-during-frame error |

## Verification
The bench builds the block with `SCLK_HALF=2` and two synchronizer stages, so a full 64-clock frame takes about 260 system cycles. It also shortens the behavioural converter's settling delay to 40 cycles. With these settings, ten conversions fit in a short run, including the boundary patterns all-ones, all-zeros and `0x80000001`. The short frames also make it cheap to inject one extra data-ready fall in the middle of a readback and to watch the overrun flag and the unchanged frame that follows.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_CFG,
        ST_WAIT,
        ST_READ
    } seq_state_e;

    typedef enum logic {
        CH_ONE = 1'b0,
        CH_TWO = 1'b1
    } chan_e;

    typedef struct packed {
        logic              valid;
        chan_e             chan;
        logic [WORD_W-1:0] word;
    } result_t;

    function automatic logic [WORD_W-1:0] cfg_frame(
        input logic [BYTE_W-1:0] wr_op,
        input logic [BYTE_W-1:0] cnt,
        input logic [BYTE_W-1:0] code,
        input logic [BYTE_W-1:0] rd_op
    );
        return {wr_op, cnt, code, rd_op};
    endfunction

    function automatic chan_e other_chan(input chan_e c);
        return (c == CH_ONE) ? CH_TWO : CH_ONE;
    endfunction

endpackage

// File: rtl/adc_drdy_edge.sv
module adc_drdy_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic drdy_n,
    output logic fall
);
    // pipe[0] is the first synchronizer flop
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-1:0], drdy_n};
        end
    end

    assign fall = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/adc_serial_shift.sv
module adc_serial_shift #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned HALF  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] tx,
    input  logic             dout,
    output logic             sclk,
    output logic             din,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] rx
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned BW = $clog2(WIDTH + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

    phase_e           ph;
    logic [CW-1:0]    tick;
    logic [BW-1:0]    left;
    logic [WIDTH-1:0] tx_sr;
    logic [WIDTH-1:0] rx_sr;
    logic             tick_end;

    assign tick_end = (tick == CW'(HALF - 1));
    assign busy     = (ph != PH_IDLE);
    assign rx       = rx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            tick  <= '0;
            left  <= '0;
            tx_sr <= '0;
            rx_sr <= '0;
            sclk  <= 1'b0;
            din   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        tx_sr <= tx;
                        left  <= BW'(WIDTH);
                        tick  <= '0;
                        ph    <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (tick_end) begin
                        tick  <= '0;
                        sclk  <= 1'b1;
                        din   <= tx_sr[WIDTH-1];
                        tx_sr <= {tx_sr[WIDTH-2:0], 1'b0};
                        ph    <= PH_HIGH;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (tick_end) begin
                        tick  <= '0;
                        sclk  <= 1'b0;
                        rx_sr <= {rx_sr[WIDTH-2:0], dout};
                        left  <= left - 1'b1;
                        if (left == BW'(1)) begin
                            done <= 1'b1;
                            ph   <= PH_IDLE;
                        end else begin
                            ph <= PH_LOW;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R8: command line moves only with a rising serial clock
    p_din_on_rise_r8: assert property (@(posedge clk) disable iff (rst)
        (din != $past(din)) |-> (sclk && !$past(sclk)));

    // R2: no serial clock while no transfer is in progress
    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE) |-> !sclk);

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_seq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MUX_WR_OP = 8'h42,
    parameter logic [BYTE_W-1:0] MUX_CNT   = 8'h00,
    parameter logic [BYTE_W-1:0] CODE_ONE  = 8'h08,
    parameter logic [BYTE_W-1:0] CODE_TWO  = 8'h18,
    parameter logic [BYTE_W-1:0] RDATA_OP  = 8'h12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              sh_done,
    input  logic [WORD_W-1:0] sh_rx,
    output logic              sh_start,
    output logic [WORD_W-1:0] sh_tx,
    output result_t           res,
    output logic              overrun
);
    seq_state_e st;
    chan_e      cur;

    function automatic logic [BYTE_W-1:0] code_of(input chan_e c);
        return (c == CH_ONE) ? CODE_ONE : CODE_TWO;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_BOOT;
            cur      <= CH_ONE;
            sh_start <= 1'b0;
            sh_tx    <= '0;
            res      <= '0;
            overrun  <= 1'b0;
        end else begin
            sh_start  <= 1'b0;
            res.valid <= 1'b0;
            if (fall && (st != ST_WAIT)) begin
                overrun <= 1'b1;
            end
            unique case (st)
                ST_BOOT: begin
                    sh_tx    <= cfg_frame(MUX_WR_OP, MUX_CNT, code_of(cur), RDATA_OP);
                    sh_start <= 1'b1;
                    st       <= ST_CFG;
                end
                ST_CFG: begin
                    if (sh_done) begin
                        st <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (fall) begin
                        sh_tx    <= '0;
                        sh_start <= 1'b1;
                        st       <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (sh_done) begin
                        res.valid <= 1'b1;
                        res.word  <= sh_rx;
                        res.chan  <= cur;
                        cur       <= other_chan(cur);
                        sh_tx     <= cfg_frame(MUX_WR_OP, MUX_CNT,
                                               code_of(other_chan(cur)), RDATA_OP);
                        sh_start  <= 1'b1;
                        st        <= ST_CFG;
                    end
                end
                default: st <= ST_BOOT;
            endcase
        end
    end

    // R3: result strobe lasts one cycle
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        res.valid |=> !res.valid);

    // R4: a delivered result is followed by the multiplexer write
    p_cfg_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        res.valid |=> (st == ST_CFG));

    // R9: overrun stays set
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

// File: rtl/adc_alt_seq.sv
module adc_alt_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned       SCLK_HALF   = 50,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [7:0]        MUX_WR_OP   = 8'h42,
    parameter logic [7:0]        MUX_CNT     = 8'h00,
    parameter logic [7:0]        CODE_ONE    = 8'h08,
    parameter logic [7:0]        CODE_TWO    = 8'h18,
    parameter logic [7:0]        RDATA_OP    = 8'h12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        drdy_n,
    input  logic        dout,
    output logic        sclk,
    output logic        din,
    output logic        res_valid,
    output logic [31:0] res_data,
    output logic        res_chan,
    output logic        overrun
);
    logic              fall;
    logic              sh_start;
    logic              sh_busy;
    logic              sh_done;
    logic [WORD_W-1:0] sh_tx;
    logic [WORD_W-1:0] sh_rx;
    result_t           res;

    adc_drdy_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .drdy_n (drdy_n),
        .fall   (fall)
    );

    adc_serial_shift #(.WIDTH(WORD_W), .HALF(SCLK_HALF)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .tx    (sh_tx),
        .dout  (dout),
        .sclk  (sclk),
        .din   (din),
        .busy  (sh_busy),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    adc_frame_ctrl #(
        .MUX_WR_OP (MUX_WR_OP),
        .MUX_CNT   (MUX_CNT),
        .CODE_ONE  (CODE_ONE),
        .CODE_TWO  (CODE_TWO),
        .RDATA_OP  (RDATA_OP)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .fall     (fall),
        .sh_done  (sh_done),
        .sh_rx    (sh_rx),
        .sh_start (sh_start),
        .sh_tx    (sh_tx),
        .res      (res),
        .overrun  (overrun)
    );

    assign res_valid = res.valid;
    assign res_data  = res.word;
    assign res_chan  = res.chan;

    // assertion support: previous delivered tag
    logic seen;
    logic last_tag;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen     <= 1'b0;
            last_tag <= 1'b0;
        end else if (res_valid) begin
            seen     <= 1'b1;
            last_tag <= res_chan;
        end
    end

    // R5: consecutive results come from different channels
    p_alternate_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && seen) |-> (res_chan != last_tag));

    // R6: the first result belongs to channel 1
    p_first_tag_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !seen) |-> (res_chan == 1'b0));

    // R2: a start is never issued while the shifter is running
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        sh_busy |-> !sh_start);

endmodule

// File: tb/adc_alt_seq_bench.sv
module adc_alt_seq_bench;
    localparam int HALF      = 2;
    localparam int SYNC      = 2;
    localparam int SETTLE    = 40;
    localparam int NCONV     = 10;
    localparam int GLITCH_AT = 6;
    localparam logic [7:0] OP_WR  = 8'h42;
    localparam logic [7:0] OP_CNT = 8'h00;
    localparam logic [7:0] OP_C1  = 8'h08;
    localparam logic [7:0] OP_C2  = 8'h18;
    localparam logic [7:0] OP_RD  = 8'h12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        drdy_n = 1'b1;
    logic        dout = 1'b0;
    logic        sclk;
    logic        din;
    logic        res_valid;
    logic [31:0] res_data;
    logic        res_chan;
    logic        overrun;

    always #5 clk = ~clk;

    adc_alt_seq #(
        .SCLK_HALF (HALF),
        .SYNC_STAGES (SYNC),
        .MUX_WR_OP (OP_WR),
        .MUX_CNT   (OP_CNT),
        .CODE_ONE  (OP_C1),
        .CODE_TWO  (OP_C2),
        .RDATA_OP  (OP_RD)
    ) u_adc_alt_seq (
        .clk       (clk),
        .rst       (rst),
        .drdy_n    (drdy_n),
        .dout      (dout),
        .sclk      (sclk),
        .din       (din),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_chan  (res_chan),
        .overrun   (overrun)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int idx, input bit ch);
        case (idx)
            0: return 32'hFFFF_FFFF;
            1: return 32'h0000_0000;
            2: return 32'h8000_0001;
            default: return (32'h5A3C_0F00 ^ (idx * 32'h01F1_3579)) ^ {31'd0, ch};
        endcase
    endfunction

    // behavioural converter and reference model
    logic        sp = 1'b0;
    int          rbit = 0;
    bit          reading = 0;
    bit          waiting = 0;
    int          settle = 0;
    logic [31:0] word = '0;
    bit          conv_chan = 0;
    logic [7:0]  sr = '0;
    int          nb = 0;
    logic [7:0]  bytes[$];
    int          cfg_idx = 0;
    int          conv_idx = 0;
    logic [31:0] exp_q[$];
    bit          expc_q[$];
    bit          idle_bad = 0;
    bit          din_bad = 0;
    bit          period_bad = 0;
    int          last_rise = -1;
    int          cyc = 0;
    int          results = 0;
    int          glitch = 0;

    always @(negedge clk) begin
        bit rise;
        bit fl;
        cyc++;
        if (!rst) begin
            rise = sclk & ~sp;
            fl   = ~sclk & sp;
            sp   = sclk;

            if (res_valid) begin
                results++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected result", res_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    bit ec;
                    e  = exp_q.pop_front();
                    ec = expc_q.pop_front();
                    chk(res_data == e, "R3 result word", res_data, e);
                    chk(res_chan == ec, "R6 channel tag", {31'd0, res_chan}, {31'd0, ec});
                end
                chk(!reading && rbit == 32, "R3 exactly 32 read clocks", rbit, 32);
                chk(nb == 0 && bytes.size() == 0, "R4 read before mux write", nb, 0);
                chk(!period_bad, "R8 sclk period", {31'd0, period_bad}, 0);
                chk(!din_bad, "R10 din low in readback", {31'd0, din_bad}, 0);
                chk(!idle_bad, "R2 sclk idle while waiting", {31'd0, idle_bad}, 0);
                chk(overrun == (results >= GLITCH_AT), "R9 overrun flag",
                    {31'd0, overrun}, {31'd0, results >= GLITCH_AT});
            end

            if (rise) begin
                if (last_rise >= 0 && (cyc - last_rise) != 2 * HALF) period_bad = 1;
                last_rise = cyc;
            end
            if (waiting && (rise || fl)) idle_bad = 1;

            if (glitch > 0) begin
                glitch--;
                drdy_n = (glitch >= 4 || glitch == 0);
            end

            if (reading) begin
                if (rise) begin
                    dout = word[31 - rbit];
                    if (rbit == 0 && glitch == 0) drdy_n = 1'b1;
                end
                if (fl) begin
                    if (din !== 1'b0) din_bad = 1;
                    rbit++;
                    if (rbit == 10 && conv_idx == GLITCH_AT) glitch = 8;
                    if (rbit == 32) begin
                        reading   = 0;
                        last_rise = -1;
                    end
                end
            end else if (fl) begin
                sr = {sr[6:0], din};
                nb++;
                if (nb == 8) begin
                    bytes.push_back(sr);
                    nb = 0;
                end
                if (bytes.size() == 4) begin
                    bit          cc;
                    logic [31:0] got;
                    logic [31:0] expw;
                    cc   = (cfg_idx % 2) == 1;
                    got  = {bytes[0], bytes[1], bytes[2], bytes[3]};
                    expw = {OP_WR, OP_CNT, cc ? OP_C2 : OP_C1, OP_RD};
                    if (cfg_idx == 0) chk(got == expw, "R1 boot mux write", got, expw);
                    else              chk(got == expw, "R5 R7 alternate write then read cmd", got, expw);
                    bytes.delete();
                    waiting   = 1;
                    settle    = SETTLE;
                    conv_chan = cc;
                    cfg_idx++;
                    last_rise = -1;
                end
            end

            if (waiting) begin
                if (settle == 0) begin
                    if (conv_idx < NCONV) begin
                        drdy_n  = 1'b0;
                        waiting = 0;
                        reading = 1;
                        rbit    = 0;
                        word    = pattern(conv_idx, conv_chan);
                        exp_q.push_back(word);
                        expc_q.push_back(conv_chan);
                        conv_idx++;
                    end
                end else begin
                    settle--;
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0, "R1 reset sclk low", {31'd0, sclk}, 0);
        chk(res_valid == 1'b0, "R1 reset no result", {31'd0, res_valid}, 0);
        chk(overrun == 1'b0, "R1 reset no overrun", {31'd0, overrun}, 0);
        rst = 1'b0;
        for (int i = 0; i < 20000 && results < NCONV; i++) @(negedge clk);
        if (results < NCONV) chk(1'b0, "watchdog expired", results, NCONV);
        repeat (100) @(negedge clk);
        chk(exp_q.size() == 0, "R3 every conversion delivered", exp_q.size(), 0);
        chk(results == NCONV, "R9 no extra frame from glitch", results, NCONV);
        chk(!idle_bad, "R2 sclk idle at end", {31'd0, idle_bad}, 0);
        chk(overrun == 1'b1, "R9 overrun held", {31'd0, overrun}, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule